// File: doc/BRIEF.md
# PWM Volume Multiplexing Mixer

This block combines several single-bit channel waveforms (three square-wave voices and one noise voice by default) into one single-bit audio stream. It does this without any arithmetic in the audio path. One free-running phase counter does two jobs. Its low bits form a ramp that each channel's volume code is compared against, which gives a per-channel loudness PWM. Its next bits choose which channel currently owns the output. Each waveform is gated by its own loudness PWM. The gated channels take turns on the output. An optional half-duty gate lowers the whole mix.

The output pin drives an external low-pass filter, which averages the fast switching into an analog level. The per-channel loudness PWM bits are also brought out, so they can light indicator LEDs. Both outputs come from flops, so they carry no glitches.

Top module: `pwm_mux_mixer`

## Requirements
- R1: While `rst_n` is low, and on the first sampled edge after it goes low, `audio_out` and every `vol_led` bit are 0, and the phase counter restarts from 0.
- R2: The phase counter advances by exactly one on every clock after reset and wraps at 2^(VOL_W+SEL_W+1). The first edge after reset evaluates count 0: ramp 0, channel 0, attenuation gate open.
- R3: Bit i of `vol_led` is 1 exactly when the volume code of channel i, read as unsigned, is greater than the ramp (count bits [VOL_W-1:0]).
- R4: A channel whose volume code is 0 never drives its `vol_led` bit high, and it never makes `audio_out` high.
- R5: A channel at the maximum volume code is on for 2^VOL_W-1 of the 2^VOL_W ramp steps. It is off only at the top ramp step.
- R6: The selected channel is the counter field [VOL_W+SEL_W-1:VOL_W]. Channel k owns the output for one whole ramp period in turn, in ascending order.
- R7: `audio_out` equals the waveform of the selected channel ANDed with that channel's loudness PWM. The waveforms and volumes of channels that are not selected have no effect on it.
- R8: With `atten_en` high, `audio_out` is forced to 0 whenever counter bit VOL_W+SEL_W is 1. With `atten_en` low, that bit has no effect.
- R9: `audio_out` and `vol_led` are registered. The value seen after a clock edge reflects the inputs and the count at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wave_in | input | NUM_CH | One waveform bit per channel |
| vol_in | input | NUM_CH*VOL_W | Volume codes, channel i in bits [i*VOL_W +: VOL_W] |
| atten_en | input | 1 | Enables the half-duty attenuation gate |
| audio_out | output | 1 | Registered single-bit mixed audio |
| vol_led | output | NUM_CH | Registered per-channel loudness PWM for indicators |

## Verification
The bench builds the mixer with four channels and a 3-bit volume, which shortens the full counter cycle to 64 clocks. As a result, each stimulus vector sweeps every ramp step, every channel slot and both halves of the attenuation gate. This puts the extreme volume codes within reach: zero is never on, and the maximum code drops out only at the top ramp step. Directed steps then check reset in mid-run, which slot comes first after reset, and the single-cycle output latency.

// File: rtl/mixer_pkg.sv
// Package: mixer_pkg
// Holds the default sizing of the mixer and the helper that derives the
// select-field width. Assumes at least two channels.
package mixer_pkg;
    localparam int DEF_NUM_CH = 4;
    localparam int DEF_VOL_W  = 6;

    // Width of the channel select field for n channels.
    function automatic int sel_width(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/mix_phase_ctr.sv
// Module: mix_phase_ctr
// Free-running binary phase counter that supplies the volume ramp, the
// channel select field and the attenuation bit. Assumes synchronous
// active-low reset and wraps naturally at 2^CNT_W.
module mix_phase_ctr #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] phase
);
    // Advance by one every clock, restart from zero in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else begin
            phase <= phase + CNT_W'(1);
        end
    end
endmodule

// File: rtl/mix_vol_pwm.sv
// Module: mix_vol_pwm
// One magnitude comparator per channel: the PWM bit is high while the
// channel's volume code exceeds the shared ramp. Purely combinational.
// Assumes volumes packed as channel i in bits [i*VOL_W +: VOL_W].
module mix_vol_pwm #(
    parameter int NUM_CH = 4,
    parameter int VOL_W  = 6
) (
    input  logic [NUM_CH*VOL_W-1:0] vol_flat,
    input  logic [VOL_W-1:0]        ramp,
    output logic [NUM_CH-1:0]       pwm
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
        // Strictly-greater compare makes code 0 silent.
        assign pwm[g] = vol_flat[g*VOL_W +: VOL_W] > ramp;
    end
endmodule

// File: rtl/mix_channel_sel.sv
// Module: mix_channel_sel
// Picks the gated channel named by the select field and applies the
// optional half-duty attenuation gate. Select codes at or above NUM_CH
// give silence. Purely combinational.
module mix_channel_sel #(
    parameter int NUM_CH = 4,
    parameter int SEL_W  = 2
) (
    input  logic [NUM_CH-1:0] gated,
    input  logic [SEL_W-1:0]  sel,
    input  logic              half,
    input  logic              atten_en,
    output logic              mixed
);
    logic picked;

    // Multiplex the selected gated channel.
    always_comb begin
        picked = 1'b0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (sel == SEL_W'(k)) begin
                picked = gated[k];
            end
        end
    end

    // Block the output during the upper half when attenuation is on.
    assign mixed = picked & ~(atten_en & half);
endmodule

// File: rtl/pwm_mux_mixer.sv
// Module: pwm_mux_mixer (top)
// Mixes NUM_CH single-bit waveforms into one single-bit stream by volume
// PWM gating and time multiplexing, with no adders or multipliers in the
// audio path. Assumes an external low-pass filter on audio_out.
// Counter layout: [VOL_W-1:0] ramp, next SEL_W bits select, top bit half.
module pwm_mux_mixer #(
    parameter int NUM_CH = mixer_pkg::DEF_NUM_CH,
    parameter int VOL_W  = mixer_pkg::DEF_VOL_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       wave_in,
    input  logic [NUM_CH*VOL_W-1:0] vol_in,
    input  logic                    atten_en,
    output logic                    audio_out,
    output logic [NUM_CH-1:0]       vol_led
);
    localparam int SEL_W = mixer_pkg::sel_width(NUM_CH);
    localparam int CNT_W = VOL_W + SEL_W + 1;

    logic [CNT_W-1:0]  phase_q;
    logic [VOL_W-1:0]  ramp;
    logic [SEL_W-1:0]  sel;
    logic              half;
    logic [NUM_CH-1:0] pwm;
    logic [NUM_CH-1:0] gated;
    logic              mixed;

    assign ramp = phase_q[VOL_W-1:0];
    assign sel  = phase_q[VOL_W +: SEL_W];
    assign half = phase_q[CNT_W-1];

    mix_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase_q)
    );

    mix_vol_pwm #(.NUM_CH(NUM_CH), .VOL_W(VOL_W)) u_pwm (
        .vol_flat (vol_in),
        .ramp     (ramp),
        .pwm      (pwm)
    );

    // Gate every waveform with its own loudness PWM.
    assign gated = wave_in & pwm;

    mix_channel_sel #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_sel (
        .gated    (gated),
        .sel      (sel),
        .half     (half),
        .atten_en (atten_en),
        .mixed    (mixed)
    );

    // Register the audio bit and the indicator bits for glitch-free pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            audio_out <= 1'b0;
            vol_led   <= '0;
        end else begin
            audio_out <= mixed;
            vol_led   <= pwm;
        end
    end
endmodule

// File: rtl/mixer_checker.sv
// Module: mixer_checker
// Temporal properties of the mixer, bound to the top module. Reads the
// phase counter alongside the ports.
module mixer_checker #(
    parameter int NUM_CH = 4,
    parameter int VOL_W  = 6,
    parameter int SEL_W  = 2,
    parameter int CNT_W  = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_CH-1:0]       wave_in,
    input logic [NUM_CH*VOL_W-1:0] vol_in,
    input logic                    atten_en,
    input logic                    audio_out,
    input logic [NUM_CH-1:0]       vol_led,
    input logic [CNT_W-1:0]        phase
);
    logic [SEL_W-1:0] sel_c;
    assign sel_c = phase[VOL_W +: SEL_W];

    // R1: outputs clear on the edge after reset is seen low.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!audio_out && vol_led == '0));

    // R2: counter steps by one while out of reset.
    p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> phase == $past(phase) + CNT_W'(1));

    // R8: attenuation gate silences the upper half.
    p_atten_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (atten_en && phase[CNT_W-1]) |=> !audio_out);

    // R7: a low waveform on the selected channel gives silence.
    p_gate_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wave_in[sel_c] |=> !audio_out);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_mute
        // R4: a zero volume code never lights its indicator.
        p_mute_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (vol_in[g*VOL_W +: VOL_W] == '0) |=> !vol_led[g]);
    end
endmodule

bind pwm_mux_mixer mixer_checker #(
    .NUM_CH (NUM_CH),
    .VOL_W  (VOL_W),
    .SEL_W  (SEL_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wave_in   (wave_in),
    .vol_in    (vol_in),
    .atten_en  (atten_en),
    .audio_out (audio_out),
    .vol_led   (vol_led),
    .phase     (phase_q)
);

// File: tb/sim_pwm_mux_mixer.sv
`timescale 1ns/1ps
module sim_pwm_mux_mixer;
    localparam int NC  = 4;
    localparam int VW  = 3;
    localparam int CW  = VW + 2 + 1;
    localparam int NV  = 8;
    localparam int PER = 1 << CW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NC-1:0]  wave_in = '0;
    logic [NC*VW-1:0] vol_in = '0;
    logic           atten_en = 1'b0;
    logic           audio_out;
    logic [NC-1:0]  vol_led;

    int checks = 0;
    int errors = 0;

    // Bench-side count of edges since reset release (from R2).
    logic [CW-1:0] mcnt;
    logic          seen;

    always #4 clk = ~clk;

    pwm_mux_mixer #(.NUM_CH(NC), .VOL_W(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .wave_in(wave_in), .vol_in(vol_in),
        .atten_en(atten_en), .audio_out(audio_out), .vol_led(vol_led)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            mcnt <= '0;
            seen <= 1'b0;
        end else begin
            mcnt <= mcnt + CW'(1);
            seen <= 1'b1;
        end
    end

    // Vector: {wave[3:0], vol ch3, ch2, ch1, ch0 (3 bits each), atten}
    localparam logic [16:0] VEC [NV] = '{
        {4'b1111, 3'd7, 3'd7, 3'd7, 3'd7, 1'b0},   // R5 full scale
        {4'b1111, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0},   // R4 all muted
        {4'b1111, 3'd1, 3'd3, 3'd5, 3'd7, 1'b1},   // R8 attenuation on
        {4'b0101, 3'd7, 3'd2, 3'd7, 3'd2, 1'b0},   // R7 unselected ignored
        {4'b1010, 3'd4, 3'd4, 3'd4, 3'd4, 1'b1},   // R8 mixed waves
        {4'b0001, 3'd0, 3'd0, 3'd0, 3'd7, 1'b0},   // R6 only slot 0 sounds
        {4'b1000, 3'd6, 3'd0, 3'd0, 3'd0, 1'b1},   // R6 only slot 3 sounds
        {4'b0110, 3'd3, 3'd1, 3'd6, 3'd0, 1'b0}    // R3 varied levels
    };

    function automatic logic exp_out(input logic [CW-1:0] c);
        logic [1:0]    s;
        logic [VW-1:0] v;
        s = c[VW +: 2];
        v = vol_in[s*VW +: VW];
        return wave_in[s] && (v > c[VW-1:0]) && !(atten_en && c[CW-1]);
    endfunction

    function automatic logic [NC-1:0] exp_led(input logic [CW-1:0] c);
        logic [NC-1:0] r;
        for (int i = 0; i < NC; i++) r[i] = vol_in[i*VW +: VW] > c[VW-1:0];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [NC-1:0] act,
                       input logic [NC-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Compare both outputs with the model value of the count just evaluated.
    task automatic check_now;
        logic [CW-1:0] c;
        c = mcnt - CW'(1);
        chk("R7 audio_out", {3'b0, audio_out}, {3'b0, exp_out(c)});
        chk("R3 vol_led", vol_led, exp_led(c));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state with nonzero inputs applied.
        wave_in = '1; vol_in = {4{3'd7}};
        chk("R1 reset audio", {3'b0, audio_out}, 4'b0);
        chk("R1 reset led", vol_led, 4'b0);

        // R2/R9: first edge after release evaluates ramp 0, channel 0.
        wave_in = 4'b0001; vol_in = {3'd0, 3'd0, 3'd0, 3'd1}; atten_en = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R2 first slot ch0", {3'b0, audio_out}, 4'b0001);
        chk("R9 led after one edge", vol_led, 4'b0001);
        @(posedge clk); @(negedge clk);
        chk("R5 ramp 1 vs code 1", {3'b0, audio_out}, 4'b0);

        // Table walk: one full counter cycle per vector.
        for (int v = 0; v < NV; v++) begin
            wave_in  = VEC[v][16:13];
            vol_in   = VEC[v][12:1];
            atten_en = VEC[v][0];
            for (int k = 0; k < PER; k++) begin
                @(posedge clk); @(negedge clk);
                check_now();
            end
        end

        // R1: reset in mid-run clears outputs and restarts the count.
        wave_in = '1; vol_in = {4{3'd7}}; atten_en = 1'b0;
        repeat (5) begin @(posedge clk); @(negedge clk); end
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 midrun audio", {3'b0, audio_out}, 4'b0);
        chk("R1 midrun led", vol_led, 4'b0);
        rst_n = 1'b1;
        wave_in = 4'b0010; vol_in = {3'd0, 3'd0, 3'd7, 3'd0};
        // R6: slot 0 first after restart, channel 1 only after VW-bit ramp.
        for (int k = 0; k < 16; k++) begin
            @(posedge clk); @(negedge clk);
            chk("R6 slot order", {3'b0, audio_out},
                {3'b0, (k >= 8 && k < 15)});
        end
        summary();
    end
endmodule